// File: doc/BRIEF.md
# Protocol-Aware Gated Countdown Timer

This block is a countdown timer for the front end of a contactless card reader. It runs on the reader's reference clock. A 12-bit prescaler turns that clock into timer ticks, and a 16-bit counter loaded from a reload value moves down by one on each tick. Two divide formulas are available: one gives an even division and one gives an odd division. Either of two external pins can gate the count. At zero the counter either reloads or stops and raises a sticky interrupt flag.

Software sets the timer up through a small write-only register port. The timer can be started directly. It can also be armed so that it starts when a transmission completes, or when the RF field comes on with field inversion enabled. Once armed, it stops when the receiver reports a protocol-dependent number of received bits. A multiple-receive option turns that stop off, and then only the stop-now strobe halts the timer.

Top module: `rc_timer`

## Requirements
- R1: After reset, `running`, `irqFlag` and `countVal` are all 0.
- R2: When `oddSel` (address 4, bit 0) is 0, one timer tick takes 2*P+2 clock cycles. P is the 12-bit prescaler value: bits 3:0 of address 0 hold P[11:8], and address 1 holds P[7:0].
- R3: When `oddSel` is 1, one timer tick takes 2*P+1 clock cycles. With P=0 the counter moves on every cycle.
- R4: A start event loads `countVal` from the reload value (address 2 holds bits 15:8, address 3 holds bits 7:0) and sets `running`. With auto-reload clear (address 0, bit 4 = 0), the tick that brings the count to 0 clears `running` and sets `irqFlag`. An idle counter holds its value.
- R5: With auto-reload set, the tick taken at a count of 0 loads the reload value instead. `running` stays 1 and `irqFlag` is not set.
- R6: Gate select is address 0, bits 6:5. 00 means no gate, 01 means pin A, 10 means pin B, and 11 behaves as no gate. While the selected pin is low (after a two-flop synchronizer), the counter holds, but `running` stays 1 and the unselected pin has no effect.
- R7: With auto-start (address 0, bit 7) set, a `txDone` pulse starts the timer. An `rfOn` pulse starts it only when field inversion (address 4, bit 3) is also set. With auto-start clear, neither pulse has any effect.
- R8: With auto-start set and multiple-receive (address 4, bit 1) clear, a running timer stops in the cycle after `rxBitCnt` first equals 4. If short-frame mode (address 4, bit 2) is set, the stop comes when `rxBitCnt` first equals 5 instead.
- R9: When multiple-receive is set, `rxBitCnt` never stops the timer. `stopNow` always halts the timer and freezes `countVal`, and it wins over a start event in the same cycle.
- R10: `irqFlag` stays set until an `irqClr` pulse. A set in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 3 | Configuration register address |
| cfgWdata | input | 8 | Configuration write data |
| startNow | input | 1 | Direct start pulse |
| txDone | input | 1 | Transmission finished pulse |
| rfOn | input | 1 | RF field switched on pulse |
| rxBitCnt | input | 4 | Bits received so far in the current frame |
| stopNow | input | 1 | Immediate stop pulse |
| gatePinA | input | 1 | First gate pin, asynchronous |
| gatePinB | input | 1 | Second gate pin, asynchronous |
| irqClr | input | 1 | Interrupt flag clear pulse |
| running | output | 1 | Timer enabled |
| irqFlag | output | 1 | Sticky zero-reached interrupt flag |
| countVal | output | 16 | Current counter value |

## Verification
The assertions assume that the start, stop and clear inputs are single-cycle pulses sampled at the clock. They also assume that `rxBitCnt` changes only between clock edges and returns to zero before each new frame, so that the first cycle at the limit is a real edge. The stimulus drives every input on the falling clock edge, keeps each pulse one cycle wide, and resets `rxBitCnt` before every start. The gate pins are the only inputs allowed to change freely, because they pass through the synchronizer.

// File: rtl/rct_pkg.sv
package rct_pkg;

  typedef enum logic [1:0] {
    GATE_OFF   = 2'b00,
    GATE_PIN_A = 2'b01,
    GATE_PIN_B = 2'b10,
    GATE_RSVD  = 2'b11
  } gateSel_e;

  typedef struct packed {
    logic     autoStart;
    gateSel_e gateSel;
    logic     autoReload;
    logic     oddSel;
    logic     multiRx;
    logic     shortFrame;
    logic     fieldInv;
  } tmrMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic halt;
  } tmrStrobe_t;

endpackage

// File: rtl/rct_regs.sv
module rct_regs
  import rct_pkg::*;
#(
  parameter int PSC_W  = 12,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  output tmrMode_t          mode,
  output logic [PSC_W-1:0]  pscVal,
  output logic [CNT_W-1:0]  reloadVal
);

  localparam int PSC_HI_W = PSC_W - DATA_W;
  localparam int CNT_HI_W = CNT_W - DATA_W;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PSCLO = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_RLDHI = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_RLDLO = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADDR_OPT   = ADDR_W'(4);

  logic [PSC_HI_W-1:0] pscHi;
  logic [DATA_W-1:0]   pscLo;
  logic [CNT_HI_W-1:0] rldHi;
  logic [DATA_W-1:0]   rldLo;
  tmrMode_t            modeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pscHi <= '0;
      pscLo <= '0;
      rldHi <= '0;
      rldLo <= '0;
      modeQ <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_MODE: begin
          modeQ.autoStart  <= cfgWdata[7];
          modeQ.gateSel    <= gateSel_e'(cfgWdata[6:5]);
          modeQ.autoReload <= cfgWdata[4];
          pscHi            <= cfgWdata[PSC_HI_W-1:0];
        end
        ADDR_PSCLO: pscLo <= cfgWdata;
        ADDR_RLDHI: rldHi <= cfgWdata[CNT_HI_W-1:0];
        ADDR_RLDLO: rldLo <= cfgWdata;
        ADDR_OPT: begin
          modeQ.oddSel     <= cfgWdata[0];
          modeQ.multiRx    <= cfgWdata[1];
          modeQ.shortFrame <= cfgWdata[2];
          modeQ.fieldInv   <= cfgWdata[3];
        end
        default: ;
      endcase
    end
  end

  assign mode      = modeQ;
  assign pscVal    = {pscHi, pscLo};
  assign reloadVal = {rldHi, rldLo};

endmodule

// File: rtl/rct_ctrl.sv
module rct_ctrl
  import rct_pkg::*;
#(
  parameter int RXCNT_W   = 4,
  parameter int RX_STD    = 4,
  parameter int RX_SHORT  = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               autoStart,
  input  logic               multiRx,
  input  logic               shortFrame,
  input  logic               fieldInv,
  input  logic               startNow,
  input  logic               txDone,
  input  logic               rfOn,
  input  logic               stopNow,
  input  logic [RXCNT_W-1:0] rxBitCnt,
  input  logic               irqClr,
  input  logic               zeroHit,
  output tmrStrobe_t         strobe,
  output logic               running,
  output logic               irqFlag
);

  localparam logic [RXCNT_W-1:0] LIM_STD   = RXCNT_W'(RX_STD);
  localparam logic [RXCNT_W-1:0] LIM_SHORT = RXCNT_W'(RX_SHORT);

  logic               runQ;
  logic               irqQ;
  logic               rxMatchQ;
  logic [RXCNT_W-1:0] rxLimit;
  logic               rxMatch;
  logic               rxStop;
  logic               autoGo;
  logic               startEv;

  assign rxLimit = shortFrame ? LIM_SHORT : LIM_STD;
  assign rxMatch = (rxBitCnt == rxLimit);
  // only the first cycle at the limit counts as a stop event
  assign rxStop  = autoStart & ~multiRx & rxMatch & ~rxMatchQ & runQ;
  assign autoGo  = autoStart & (txDone | (fieldInv & rfOn));
  assign startEv = startNow | autoGo;

  always_comb begin
    strobe.halt = stopNow | rxStop;
    strobe.load = startEv & ~strobe.halt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      irqQ     <= 1'b0;
      rxMatchQ <= 1'b0;
    end else begin
      rxMatchQ <= rxMatch;
      if (strobe.halt)      runQ <= 1'b0;
      else if (strobe.load) runQ <= 1'b1;
      else if (zeroHit)     runQ <= 1'b0;
      if (zeroHit)          irqQ <= 1'b1;
      else if (irqClr)      irqQ <= 1'b0;
    end
  end

  assign running = runQ;
  assign irqFlag = irqQ;

endmodule

// File: rtl/rct_dp.sv
module rct_dp
  import rct_pkg::*;
#(
  parameter int PSC_W       = 12,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic             running,
  input  gateSel_e         gateSel,
  input  logic             autoReload,
  input  logic             oddSel,
  input  logic [PSC_W-1:0] pscVal,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             gatePinA,
  input  logic             gatePinB,
  output logic [CNT_W-1:0] countVal,
  output logic             zeroHit
);

  localparam int DIV_W    = PSC_W + 1;
  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinSync;
  logic [DIV_W-1:0]    divLimit;
  logic [DIV_W-1:0]    pscCnt;
  logic [CNT_W-1:0]    cntQ;
  logic                tick;
  logic                gateOpen;
  logic                step;

  assign pinRaw = {gatePinB, gatePinA};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= '0;
      else       stage <= {stage[SYNC_STAGES-2:0], pinRaw[g]};
    end
    assign pinSync[g] = stage[SYNC_STAGES-1];
  end

  always_comb begin
    case (gateSel)
      GATE_PIN_A: gateOpen = pinSync[0];
      GATE_PIN_B: gateOpen = pinSync[1];
      default:    gateOpen = 1'b1;
    endcase
  end

  // terminal count 2P+1 (even formula) or 2P (odd formula)
  assign divLimit = {pscVal, ~oddSel};
  assign tick     = running & (pscCnt == divLimit) & ~strobe.halt & ~strobe.load;
  assign step     = tick & gateOpen;
  assign zeroHit  = step & ~autoReload & (cntQ <= CNT_W'(1));

  // the prescaler runs whatever the gate, so its phase survives a closed gate
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   pscCnt <= '0;
    else if (strobe.load || !running || strobe.halt) pscCnt <= '0;
    else if (pscCnt == divLimit)                 pscCnt <= '0;
    else                                         pscCnt <= pscCnt + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.load) begin
      cntQ <= reloadVal;
    end else if (step) begin
      if (cntQ == '0 && autoReload)            cntQ <= reloadVal;
      else if (cntQ <= CNT_W'(1) && !autoReload) cntQ <= '0;
      else                                     cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign countVal = cntQ;

endmodule

// File: rtl/rc_timer.sv
module rc_timer
  import rct_pkg::*;
#(
  parameter int PSC_W       = 12,
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int RXCNT_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic               startNow,
  input  logic               txDone,
  input  logic               rfOn,
  input  logic [RXCNT_W-1:0] rxBitCnt,
  input  logic               stopNow,
  input  logic               gatePinA,
  input  logic               gatePinB,
  input  logic               irqClr,
  output logic               running,
  output logic               irqFlag,
  output logic [CNT_W-1:0]   countVal
);

  tmrMode_t         mode;
  tmrStrobe_t       strobe;
  logic [PSC_W-1:0] pscVal;
  logic [CNT_W-1:0] reloadVal;
  logic             zeroHit;

  rct_regs #(.PSC_W(PSC_W), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .mode(mode), .pscVal(pscVal), .reloadVal(reloadVal)
  );

  rct_ctrl #(.RXCNT_W(RXCNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .autoStart(mode.autoStart), .multiRx(mode.multiRx),
    .shortFrame(mode.shortFrame), .fieldInv(mode.fieldInv),
    .startNow(startNow), .txDone(txDone), .rfOn(rfOn), .stopNow(stopNow),
    .rxBitCnt(rxBitCnt), .irqClr(irqClr), .zeroHit(zeroHit),
    .strobe(strobe), .running(running), .irqFlag(irqFlag)
  );

  rct_dp #(.PSC_W(PSC_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .running(running),
    .gateSel(mode.gateSel), .autoReload(mode.autoReload), .oddSel(mode.oddSel),
    .pscVal(pscVal), .reloadVal(reloadVal),
    .gatePinA(gatePinA), .gatePinB(gatePinB),
    .countVal(countVal), .zeroHit(zeroHit)
  );

endmodule

// File: rtl/rc_timer_chk.sv
module rc_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startNow,
  input logic             txDone,
  input logic             rfOn,
  input logic             stopNow,
  input logic             irqClr,
  input logic             running,
  input logic             irqFlag,
  input logic [CNT_W-1:0] countVal
);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !irqClr |=> irqFlag);

  // R9
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopNow |=> !running);

  // R9
  stop_freezes_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopNow |=> $stable(countVal));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running && !startNow && !txDone && !rfOn |=> $stable(countVal));

  // R4
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> countVal == '0);

  // R4
  start_runs_chk: assert property (@(posedge clk) disable iff (!rstN)
    startNow && !stopNow && !running |=> running);

endmodule

bind rc_timer rc_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .startNow(startNow), .txDone(txDone), .rfOn(rfOn),
  .stopNow(stopNow), .irqClr(irqClr), .running(running), .irqFlag(irqFlag),
  .countVal(countVal)
);

// File: tb/test_rc_timer.sv
module test_rc_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgWdata = '0;
  logic        startNow = 1'b0;
  logic        txDone = 1'b0;
  logic        rfOn = 1'b0;
  logic [3:0]  rxBitCnt = '0;
  logic        stopNow = 1'b0;
  logic        gatePinA = 1'b0;
  logic        gatePinB = 1'b0;
  logic        irqClr = 1'b0;
  logic        running;
  logic        irqFlag;
  logic [15:0] countVal;

  int nCmp = 0;
  int nErr = 0;

  always #10 clk = ~clk;

  rc_timer i_rc_timer (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .startNow(startNow), .txDone(txDone), .rfOn(rfOn), .rxBitCnt(rxBitCnt),
    .stopNow(stopNow), .gatePinA(gatePinA), .gatePinB(gatePinB), .irqClr(irqClr),
    .running(running), .irqFlag(irqFlag), .countVal(countVal)
  );

  function automatic int expPeriod(int p, bit odd);
    return odd ? 2 * p + 1 : 2 * p + 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(a); cfgWdata = 8'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // R11-style layout stated in R2, R4..R9: addr0 {autoStart,gate[1:0],autoReload,P[11:8]}
  task automatic cfgTimer(int p, bit odd, int rld, bit autoRld, int gate,
                          bit autoSt, bit multi, bit shortF, bit fInv);
    wr(0, (int'(autoSt) << 7) | ((gate & 3) << 5) | (int'(autoRld) << 4) | ((p >> 8) & 15));
    wr(1, p & 255);
    wr(2, (rld >> 8) & 255);
    wr(3, rld & 255);
    wr(4, int'(odd) | (int'(multi) << 1) | (int'(shortF) << 2) | (int'(fInv) << 3));
  endtask

  task automatic pulseStart();
    @(negedge clk); startNow = 1'b1;
    @(negedge clk); startNow = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopNow = 1'b1;
    @(negedge clk); stopNow = 1'b0;
  endtask

  task automatic pulseTx();
    @(negedge clk); txDone = 1'b1;
    @(negedge clk); txDone = 1'b0;
  endtask

  task automatic pulseRf();
    @(negedge clk); rfOn = 1'b1;
    @(negedge clk); rfOn = 1'b0;
  endtask

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles until countVal next changes
  task automatic measure(output int n);
    logic [15:0] prev;
    prev = countVal;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (countVal == prev && n < 10000);
  endtask

  task automatic periodTest(string req, int p, bit odd);
    int n;
    cfgTimer(p, odd, 1000, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulseStart();
    measure(n);
    chk(req, n, expPeriod(p, odd));
    measure(n);
    chk(req, n, expPeriod(p, odd));
    pulseStop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
    $finish;
  end

  initial begin
    int v;
    void'($urandom(32'd20240517));
    waitCyc(3);
    // R1 reset state
    chk("R1 running", int'(running), 0);
    chk("R1 irqFlag", int'(irqFlag), 0);
    chk("R1 countVal", int'(countVal), 0);
    rstN = 1'b1;
    waitCyc(2);

    // R2 / R3 directed corners
    periodTest("R2 even P=0", 0, 1'b0);
    periodTest("R2 even P=1", 1, 1'b0);
    periodTest("R2 even P=4095", 4095, 1'b0);
    periodTest("R3 odd P=0", 0, 1'b1);
    periodTest("R3 odd P=1", 1, 1'b1);
    periodTest("R3 odd P=4095", 4095, 1'b1);

    // R2 / R3 random prescalers
    for (int t = 0; t < 16; t++) begin
      int p;
      bit o;
      p = int'($urandom_range(0, 40));
      o = 1'($urandom_range(0, 1));
      periodTest(o ? "R3 random" : "R2 random", p, o);
    end

    // R4 stop at zero, irq set
    cfgTimer(0, 1'b1, 3, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulseStart();
    chk("R4 load", int'(countVal), 3);
    chk("R4 running", int'(running), 1);
    waitCyc(10);
    chk("R4 zero", int'(countVal), 0);
    chk("R4 stopped", int'(running), 0);
    chk("R4 irq", int'(irqFlag), 1);
    waitCyc(5);
    chk("R10 sticky", int'(irqFlag), 1);
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
    chk("R10 cleared", int'(irqFlag), 0);

    // R5 auto reload
    cfgTimer(0, 1'b1, 3, 1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    pulseStart();
    v = 3;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      v = (v == 0) ? 3 : v - 1;
      chk("R5 sequence", int'(countVal), v);
    end
    chk("R5 running", int'(running), 1);
    chk("R5 no irq", int'(irqFlag), 0);
    pulseStop();

    // R6 gate on pin A
    cfgTimer(0, 1'b1, 50, 1'b0, 1, 1'b0, 1'b0, 1'b0, 1'b0);
    gatePinA = 1'b0; gatePinB = 1'b1;
    pulseStart();
    waitCyc(10);
    chk("R6 A closed holds", int'(countVal), 50);
    chk("R6 A closed running", int'(running), 1);
    gatePinA = 1'b1;
    waitCyc(10);
    chk("R6 A open counts", int'(countVal < 50), 1);
    pulseStop();

    // R6 gate on pin B
    cfgTimer(0, 1'b1, 50, 1'b0, 2, 1'b0, 1'b0, 1'b0, 1'b0);
    gatePinA = 1'b1; gatePinB = 1'b0;
    waitCyc(4);
    pulseStart();
    waitCyc(10);
    chk("R6 B closed holds", int'(countVal), 50);
    gatePinB = 1'b1;
    waitCyc(10);
    chk("R6 B open counts", int'(countVal < 50), 1);
    pulseStop();

    // R6 reserved select is ungated
    cfgTimer(0, 1'b1, 50, 1'b0, 3, 1'b0, 1'b0, 1'b0, 1'b0);
    gatePinA = 1'b0; gatePinB = 1'b0;
    waitCyc(4);
    pulseStart();
    waitCyc(10);
    chk("R6 reserved counts", int'(countVal), 40);
    pulseStop();

    // R7 auto start
    cfgTimer(0, 1'b0, 500, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    pulseRf();
    chk("R7 rfOn without inversion", int'(running), 0);
    pulseTx();
    chk("R7 txDone starts", int'(running), 1);
    pulseStop();
    cfgTimer(0, 1'b0, 500, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b1);
    pulseRf();
    chk("R7 rfOn with inversion", int'(running), 1);
    pulseStop();
    cfgTimer(0, 1'b0, 500, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b1);
    pulseTx();
    pulseRf();
    chk("R7 auto-start off ignored", int'(running), 0);

    // R8 standard frame stops at 4
    cfgTimer(0, 1'b0, 500, 1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
    rxBitCnt = 0;
    pulseTx();
    @(negedge clk); rxBitCnt = 3;
    waitCyc(3);
    chk("R8 std bit 3 runs", int'(running), 1);
    rxBitCnt = 4;
    waitCyc(2);
    chk("R8 std bit 4 stops", int'(running), 0);
    rxBitCnt = 0;

    // R8 short frame stops at 5
    cfgTimer(0, 1'b0, 500, 1'b0, 0, 1'b1, 1'b0, 1'b1, 1'b0);
    pulseTx();
    @(negedge clk); rxBitCnt = 4;
    waitCyc(3);
    chk("R8 short bit 4 runs", int'(running), 1);
    rxBitCnt = 5;
    waitCyc(2);
    chk("R8 short bit 5 stops", int'(running), 0);
    rxBitCnt = 0;

    // R9 multiple receive never stops, stopNow does
    cfgTimer(0, 1'b0, 500, 1'b0, 0, 1'b1, 1'b1, 1'b1, 1'b0);
    pulseTx();
    @(negedge clk); rxBitCnt = 5;
    waitCyc(3);
    rxBitCnt = 4;
    waitCyc(3);
    chk("R9 multi-rx keeps running", int'(running), 1);
    rxBitCnt = 0;
    pulseStop();
    chk("R9 stopNow halts", int'(running), 0);
    v = int'(countVal);
    waitCyc(10);
    chk("R9 count frozen", int'(countVal), v);

    // R9 stop wins over start in the same cycle
    @(negedge clk); startNow = 1'b1; stopNow = 1'b1;
    @(negedge clk); startNow = 1'b0; stopNow = 1'b0;
    chk("R9 stop beats start", int'(running), 0);
    chk("R9 no reload on clash", int'(countVal), v);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
    $finish;
  end

endmodule